// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block tracks which requester holds a reservation on which cache line. It watches a stream of completed memory operations, one per cycle at most. A linked-load completion reserves its line for the requester that issued it. A conditional-store completion reports whether that requester still held the line. Every conditional store drops the line's reservation. Any other write-type completion from the holder drops it too. A small table of entries holds the reservations. When the table is full, a new reservation evicts the one that was allocated earliest.

The block also drives a queue stall handshake for locked read-modify-write pairs. The locked read completion emits a one-cycle block pulse naming its line. The locked write completion emits a one-cycle unblock pulse naming its line. A mode input switches reservation tracking off. In that mode the table is left untouched and every conditional store reports success. All results are registered and appear one cycle after the completion strobe.

Top module: `resmon`

## Requirements
- R1: After reset no reservation exists and all outputs (`sc_done`, `sc_pass`, `q_block`, `q_unblock`, `q_line`) are 0.
- R2: A completion with `cmp_op`=2 (linked load) reserves `cmp_line` for `cmp_id`. A later completion with `cmp_op`=3 (conditional store) to that line with the same id makes `sc_done`=1 and `sc_pass`=1 exactly one cycle after its strobe.
- R3: A conditional store (`cmp_op`=3) fails (`sc_done`=1, `sc_pass`=0) when its line has no reservation or the reservation belongs to another id. `sc_pass` is 0 whenever `sc_done` is 0.
- R4: Every conditional store removes its line's reservation, whether it passes or fails and whichever id issued it.
- R5: A store (`cmp_op`=1), flush (6), locked read (4) or locked write (5) removes the line's reservation only if the issuing id holds it. The same operation from another id leaves the reservation in place.
- R6: A linked load to a line that is already reserved re-tags it to the new id, so only the latest linked-load requester can pass.
- R7: The table holds `NUM_ENT` lines, kept in allocation order. A linked load to a new line when the table is full evicts the earliest allocated entry. Slots freed by removal are reused without eviction.
- R8: While `llsc_off`=1, linked loads and writes leave the table unchanged. A conditional store reports `sc_pass`=1 and removes nothing.
- R9: A locked read (`cmp_op`=4) makes `q_block`=1 and a locked write (`cmp_op`=5) makes `q_unblock`=1, each for one cycle, one cycle after the strobe, with `q_line` equal to the strobed line. Otherwise `q_line`=0, and `q_block` and `q_unblock` are never 1 together.
- R10: Plain loads (`cmp_op`=0), code 7 and cycles with `cmp_vld`=0 change no reservation and produce no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| llsc_off | input | 1 | Disables reservation tracking; conditional stores then pass |
| cmp_vld | input | 1 | Completion strobe |
| cmp_op | input | 3 | Completed operation code |
| cmp_line | input | LINE_W | Line address of the completion |
| cmp_id | input | ID_W | Requester identifier |
| sc_done | output | 1 | Conditional-store result valid |
| sc_pass | output | 1 | Conditional-store success |
| q_block | output | 1 | Stall the request queue for `q_line` |
| q_unblock | output | 1 | Release the request queue for `q_line` |
| q_line | output | LINE_W | Line for block/unblock, else 0 |

## Verification
The bench builds the block with `NUM_ENT`=3, `LINE_W`=6 and `ID_W`=2. The three-entry table fills after three linked loads, so eviction of the earliest entry and reuse of freed slots can be reached in a few cycles. Two-bit ids give enough distinct requesters for cross-requester failures and re-tagging. The narrow line field keeps the chosen line values readable while still separating neighbouring lines.

// File: rtl/resmon_pkg.sv
package resmon_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LL    = 3'd2,
        OP_SC    = 3'd3,
        OP_LKRD  = 3'd4,
        OP_LKWR  = 3'd5,
        OP_FLUSH = 3'd6,
        OP_NONE  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        CMD_NOP    = 2'd0,
        CMD_SETID  = 2'd1,
        CMD_REMOVE = 2'd2,
        CMD_APPEND = 2'd3
    } tcmd_e;

endpackage

// File: rtl/resmon_table.sv
module resmon_table
    import resmon_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int LINE_W  = 32,
    parameter int ID_W    = 4,
    localparam int IDX_W  = $clog2(NUM_ENT),
    localparam int CNT_W  = $clog2(NUM_ENT + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  tcmd_e                          cmd,
    input  logic [IDX_W-1:0]               idx,
    input  logic [LINE_W-1:0]              line_in,
    input  logic [ID_W-1:0]                id_in,
    output logic [NUM_ENT-1:0]             vld_o,
    output logic [NUM_ENT-1:0][LINE_W-1:0] line_o,
    output logic [NUM_ENT-1:0][ID_W-1:0]   id_o
);

    logic [NUM_ENT-1:0]             vld_d,  vld_q;
    logic [NUM_ENT-1:0][LINE_W-1:0] line_d, line_q;
    logic [NUM_ENT-1:0][ID_W-1:0]   id_d,   id_q;

    logic [CNT_W-1:0] count;
    logic             full;
    logic             rem_en, app_en;
    logic [IDX_W-1:0] rem_idx;
    logic [CNT_W-1:0] slot;

    always_comb begin
        count = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            count = count + CNT_W'(vld_q[i]);
        end
        full = (count == CNT_W'(NUM_ENT));
    end

    always_comb begin
        vld_d   = vld_q;
        line_d  = line_q;
        id_d    = id_q;
        rem_en  = 1'b0;
        rem_idx = idx;
        app_en  = 1'b0;
        slot    = count;
        unique case (cmd)
            CMD_SETID:  id_d[idx] = id_in;
            CMD_REMOVE: rem_en = 1'b1;
            CMD_APPEND: begin
                app_en = 1'b1;
                if (full) begin
                    rem_en  = 1'b1;
                    rem_idx = '0;
                    slot    = CNT_W'(NUM_ENT - 1);
                end
            end
            default: ;
        endcase
        if (rem_en) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                if (i >= int'(rem_idx)) begin
                    if (i < NUM_ENT - 1) begin
                        vld_d[i]  = vld_q[i+1];
                        line_d[i] = line_q[i+1];
                        id_d[i]   = id_q[i+1];
                    end else begin
                        vld_d[i] = 1'b0;
                    end
                end
            end
        end
        if (app_en) begin
            vld_d[IDX_W'(slot)]  = 1'b1;
            line_d[IDX_W'(slot)] = line_in;
            id_d[IDX_W'(slot)]   = id_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            line_q <= '0;
            id_q   <= '0;
        end else begin
            vld_q  <= vld_d;
            line_q <= line_d;
            id_q   <= id_d;
        end
    end

    assign vld_o  = vld_q;
    assign line_o = line_q;
    assign id_o   = id_q;

    // R7
    prefix_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[NUM_ENT-1] |-> vld_q[0]);

    // R4
    remove_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REMOVE) |=> ($countones(vld_q) + 1 == $past($countones(vld_q))));

    // R7
    append_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_APPEND && !full) |=> ($countones(vld_q) == $past($countones(vld_q)) + 1));

endmodule

// File: rtl/resmon_match.sv
module resmon_match #(
    parameter int NUM_ENT = 4,
    parameter int LINE_W  = 32,
    parameter int ID_W    = 4,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_ENT-1:0]             vld,
    input  logic [NUM_ENT-1:0][LINE_W-1:0] line,
    input  logic [NUM_ENT-1:0][ID_W-1:0]   id,
    input  logic [LINE_W-1:0]              key,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx,
    output logic [ID_W-1:0]                hit_id
);

    logic [NUM_ENT-1:0] hv;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        assign hv[g] = vld[g] && (line[g] == key);
    end

    always_comb begin
        hit_idx = '0;
        hit_id  = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (hv[i]) begin
                hit_idx = IDX_W'(i);
                hit_id  = id[i];
            end
        end
    end

    assign hit = |hv;

    // R6
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hv));

endmodule

// File: rtl/resmon.sv
module resmon
    import resmon_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int LINE_W  = 32,
    parameter int ID_W    = 4,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              llsc_off,
    input  logic              cmp_vld,
    input  logic [2:0]        cmp_op,
    input  logic [LINE_W-1:0] cmp_line,
    input  logic [ID_W-1:0]   cmp_id,
    output logic              sc_done,
    output logic              sc_pass,
    output logic              q_block,
    output logic              q_unblock,
    output logic [LINE_W-1:0] q_line
);

    typedef struct packed {
        logic              sc_done;
        logic              sc_pass;
        logic              blk;
        logic              unblk;
        logic [LINE_W-1:0] line;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_ENT-1:0]             t_vld;
    logic [NUM_ENT-1:0][LINE_W-1:0] t_line;
    logic [NUM_ENT-1:0][ID_W-1:0]   t_id;
    logic                           hit;
    logic [IDX_W-1:0]               hit_idx;
    logic [ID_W-1:0]                hit_id;
    tcmd_e                          tcmd;
    op_e                            op;
    logic                           own;

    resmon_table #(.NUM_ENT(NUM_ENT), .LINE_W(LINE_W), .ID_W(ID_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (tcmd),
        .idx     (hit_idx),
        .line_in (cmp_line),
        .id_in   (cmp_id),
        .vld_o   (t_vld),
        .line_o  (t_line),
        .id_o    (t_id)
    );

    resmon_match #(.NUM_ENT(NUM_ENT), .LINE_W(LINE_W), .ID_W(ID_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (t_vld),
        .line    (t_line),
        .id      (t_id),
        .key     (cmp_line),
        .hit     (hit),
        .hit_idx (hit_idx),
        .hit_id  (hit_id)
    );

    always_comb begin
        op   = op_e'(cmp_op);
        own  = hit && (hit_id == cmp_id);
        tcmd = CMD_NOP;
        if (cmp_vld && !llsc_off) begin
            unique case (op)
                OP_LL:    tcmd = hit ? CMD_SETID : CMD_APPEND;
                OP_SC:    if (hit) tcmd = CMD_REMOVE;
                OP_STORE, OP_FLUSH, OP_LKRD, OP_LKWR:
                          if (own) tcmd = CMD_REMOVE;
                default:  ;
            endcase
        end
        out_d.sc_done = cmp_vld && (op == OP_SC);
        out_d.sc_pass = cmp_vld && (op == OP_SC) && (llsc_off || own);
        out_d.blk     = cmp_vld && (op == OP_LKRD);
        out_d.unblk   = cmp_vld && (op == OP_LKWR);
        out_d.line    = (out_d.blk || out_d.unblk) ? cmp_line : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sc_done   = out_q.sc_done;
    assign sc_pass   = out_q.sc_pass;
    assign q_block   = out_q.blk;
    assign q_unblock = out_q.unblk;
    assign q_line    = out_q.line;

    // R2
    sc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_vld && cmp_op == 3'd3) |=> sc_done);

    // R3
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> sc_done);

    // R8
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_vld && cmp_op == 3'd3 && llsc_off) |=> sc_pass);

    // R8
    bypass_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        llsc_off |=> $stable(t_vld));

    // R9
    block_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_vld && cmp_op == 3'd4) |=> (q_block && q_line == $past(cmp_line)));

    // R9
    no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_block && q_unblock));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_vld |=> (!sc_done && !q_block && !q_unblock && $stable(t_vld)));

endmodule

// File: tb/resmon_tb.sv
module resmon_tb;

    localparam int N  = 3;
    localparam int LW = 6;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          llsc_off = 1'b0;
    logic          cmp_vld = 1'b0;
    logic [2:0]    cmp_op = '0;
    logic [LW-1:0] cmp_line = '0;
    logic [IW-1:0] cmp_id = '0;
    logic          sc_done, sc_pass, q_block, q_unblock;
    logic [LW-1:0] q_line;

    always #2.5 clk = ~clk;

    resmon #(.NUM_ENT(N), .LINE_W(LW), .ID_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .llsc_off(llsc_off), .cmp_vld(cmp_vld),
        .cmp_op(cmp_op), .cmp_line(cmp_line), .cmp_id(cmp_id),
        .sc_done(sc_done), .sc_pass(sc_pass), .q_block(q_block),
        .q_unblock(q_unblock), .q_line(q_line)
    );

    typedef struct { int line; int id; } ent_t;
    ent_t mq[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic          e_done = 0, e_pass = 0, e_blk = 0, e_unblk = 0;
    logic [LW-1:0] e_line = 0;
    string         e_tag = "R1";

    function automatic int find(int ln);
        foreach (mq[i]) if (mq[i].line == ln) return i;
        return -1;
    endfunction

    task automatic compare();
        checks++;
        if ({sc_done, sc_pass, q_block, q_unblock, q_line} !==
            {e_done, e_pass, e_blk, e_unblk, e_line}) begin
            fails++;
            $display("FAIL %s: got done=%0b pass=%0b blk=%0b unblk=%0b line=%0d exp done=%0b pass=%0b blk=%0b unblk=%0b line=%0d",
                     e_tag, sc_done, sc_pass, q_block, q_unblock, q_line,
                     e_done, e_pass, e_blk, e_unblk, e_line);
        end
    endtask

    task automatic step(bit v, int op, int ln, int id, bit off, string tag);
        int k;
        @(negedge clk);
        compare();
        cmp_vld = v; cmp_op = 3'(op); cmp_line = LW'(ln); cmp_id = IW'(id);
        llsc_off = off;
        e_done = 0; e_pass = 0; e_blk = 0; e_unblk = 0; e_line = 0; e_tag = tag;
        if (v) begin
            k = find(ln);
            case (op)
                2: if (!off) begin
                       if (k >= 0) mq[k].id = id;
                       else begin
                           if (mq.size() == N) void'(mq.pop_front());
                           mq.push_back('{ln, id});
                       end
                   end
                3: begin
                       e_done = 1;
                       e_pass = off || (k >= 0 && mq[k].id == id);
                       if (!off && k >= 0) mq.delete(k);
                   end
                1, 4, 5, 6: if (!off && k >= 0 && mq[k].id == id) mq.delete(k);
                default: ;
            endcase
            if (op == 4) begin e_blk = 1; e_line = LW'(ln); end
            if (op == 5) begin e_unblk = 1; e_line = LW'(ln); end
        end
    endtask

    task automatic idle(string tag);
        step(0, 3, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(); // R1 reset state
        rst_n = 1;
        idle("R1"); idle("R1");
        step(1, 3, 5, 1, 0, "R1"); // no reservation after reset
        idle("R1");
        // R2 basic pass, R4 cleared by pass
        step(1, 2, 5, 1, 0, "R2");
        step(1, 3, 5, 1, 0, "R2");
        step(1, 3, 5, 1, 0, "R4");
        idle("R4");
        // R3 wrong id fails, R4 failing SC clears
        step(1, 2, 5, 1, 0, "R3");
        step(1, 3, 5, 2, 0, "R3");
        step(1, 3, 5, 1, 0, "R4");
        // R5 foreign writes keep, own writes clear
        step(1, 2, 7, 1, 0, "R5");
        step(1, 1, 7, 2, 0, "R5");
        step(1, 6, 7, 3, 0, "R5");
        step(1, 3, 7, 1, 0, "R5");
        for (int op = 1; op <= 6; op++) begin
            if (op == 2 || op == 3) continue;
            step(1, 2, 8, 2, 0, "R5");
            step(1, op, 8, 2, 0, "R5");
            step(1, 3, 8, 2, 0, "R5");
        end
        // R6 retag
        step(1, 2, 9, 0, 0, "R6");
        step(1, 2, 9, 3, 0, "R6");
        step(1, 3, 9, 3, 0, "R6");
        step(1, 2, 9, 0, 0, "R6");
        step(1, 2, 9, 3, 0, "R6");
        step(1, 3, 9, 0, 0, "R6");
        // R7 eviction of earliest
        step(1, 2, 1, 1, 0, "R7");
        step(1, 2, 2, 1, 0, "R7");
        step(1, 2, 3, 1, 0, "R7");
        step(1, 2, 4, 1, 0, "R7");
        step(1, 3, 1, 1, 0, "R7");
        step(1, 3, 2, 1, 0, "R7");
        step(1, 3, 3, 1, 0, "R7");
        step(1, 3, 4, 1, 0, "R7");
        // R7 reuse freed slot without eviction
        step(1, 2, 10, 2, 0, "R7");
        step(1, 2, 11, 2, 0, "R7");
        step(1, 2, 12, 2, 0, "R7");
        step(1, 1, 11, 2, 0, "R7");
        step(1, 2, 13, 2, 0, "R7");
        step(1, 2, 14, 2, 0, "R7");
        step(1, 3, 10, 2, 0, "R7");
        step(1, 3, 12, 2, 0, "R7");
        step(1, 3, 13, 2, 0, "R7");
        step(1, 3, 14, 2, 0, "R7");
        // R8 bypass mode
        step(1, 2, 20, 1, 1, "R8");
        step(1, 3, 20, 1, 0, "R8");
        step(1, 2, 21, 1, 0, "R8");
        step(1, 3, 21, 2, 1, "R8");
        step(1, 1, 21, 1, 1, "R8");
        step(1, 3, 30, 0, 1, "R8");
        step(1, 3, 21, 1, 0, "R8");
        // R9 block / unblock
        step(1, 4, 33, 1, 0, "R9");
        step(1, 5, 33, 1, 0, "R9");
        step(1, 4, 63, 0, 0, "R9");
        idle("R9");
        step(1, 5, 17, 2, 0, "R9");
        // R10 loads, code 7, invalid strobe
        step(1, 2, 40, 3, 0, "R10");
        step(1, 0, 40, 3, 0, "R10");
        step(1, 7, 40, 3, 0, "R10");
        step(0, 1, 40, 3, 0, "R10");
        step(0, 4, 40, 3, 0, "R10");
        step(1, 3, 40, 3, 0, "R10");
        idle("R10");
        idle("R10");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule